// File: doc/BRIEF.md
# SPI Frame Queue Burst Sequencer

This block carries one whole Ethernet frame per request between a local byte source or sink and the transmit and receive queues of an external MAC controller, reached over a byte-wide serial exchange port. The host raises a request with a direction, a payload length and, for transmit, the free queue space last reported by the controller. The sequencer first screens the request. If it passes, the sequencer opens queue access, drops chip select and runs the whole burst inside that one chip-select window. It then closes the window and queue access and, for transmit, pulses a start-transmission strobe.

A transmit burst is a write command byte, a four-byte header and the payload, followed by zero padding. The header holds a control word with a completion-interrupt flag and a rolling frame number, then the byte count. A receive burst is a read command byte and eight filler exchanges whose returned bytes are thrown away. The payload bytes that follow are handed out on a valid/ready stream, and the padding exchanges after them are discarded. The bit shifter sits outside this block. Each byte moves through a start/done handshake, which carries the byte to send and returns the byte received.

Top module: `fq_spi_burst_seq`

## Requirements
- R1: A request is taken only while `busy` is low. `busy` is high from the cycle after acceptance up to and including the single-cycle `done` pulse. A request raised while `busy` is high has no effect.
- R2: A request whose length exceeds MAX_FRAME (1518) ends with `err_code` 1, and neither queue access, chip select nor any byte exchange occurs. A length of exactly 1518 is accepted.
- R3: A transmit request ends with `err_code` 2 and no bus activity when length + 8 is greater than `req_free`. Equality is accepted. Receive requests ignore `req_free`. A successful request ends with `err_code` 0.
- R4: `qacc` rises before `cs_n` falls and falls only after `cs_n` has risen. Every byte exchange of a burst happens during one low period of `cs_n`.
- R5: A transmit burst sends 0xF0, then the control word low and high bytes, then the length low and high bytes, then the payload in source order with one `tx_pop` per byte, then zero bytes until the payload count is a multiple of 4.
- R6: The control word has bit 15 set and bits [5:0] equal to the frame number. The frame number is 0 after reset, rises by one after each completed transmit burst and wraps at 64. Rejected and receive requests leave it unchanged.
- R7: After a successful transmit, `enq` pulses for one cycle while `qacc` and chip select are inactive. A receive burst never pulses `enq`.
- R8: A receive burst sends 0xF0-free traffic: the byte 0x80, then 8 filler exchanges, then one exchange per payload byte, then padding exchanges up to a multiple of 4. Every byte sent after the command is 0x00, and only the payload responses appear on the `rx` stream, in order.
- R9: `rx_valid` with `rx_data` holds until `rx_ready` is seen, and no exchange starts while a received byte is pending.
- R10: Each `xfer_start` is a single-cycle pulse, and the next one is given only after `xfer_done` has answered the previous one. A payload exchange on transmit waits for `tx_valid`.
- R11: After reset, `cs_n` is high and `qacc`, `busy`, `done`, `enq` and `xfer_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_dir | input | 1 | 0 transmit, 1 receive |
| req_len | input | 16 | Payload length in bytes |
| req_free | input | 16 | Free transmit queue space reported by the controller |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 length error, 2 space error; valid with `done` |
| tx_valid | input | 1 | Transmit payload byte available |
| tx_data | input | 8 | Transmit payload byte |
| tx_pop | output | 1 | Transmit payload byte consumed |
| rx_valid | output | 1 | Received payload byte available |
| rx_data | output | 8 | Received payload byte |
| rx_ready | input | 1 | Sink accepts the received byte |
| cs_n | output | 1 | Chip select, active low |
| qacc | output | 1 | Queue data access enable |
| enq | output | 1 | Start-transmission strobe |
| xfer_start | output | 1 | Begin one byte exchange |
| xfer_tx | output | 8 | Byte to send, valid with `xfer_start` |
| xfer_done | input | 1 | Byte exchange finished |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |

## Verification
A rejected request produces `done` exactly two cycles after the request cycle, and the bench counts cycles from the request to check that timing. Successful bursts have a variable duration, because the serial responder answers each exchange 1 to 3 cycles after its start and the payload source and the receive sink stall on a rotating pattern. For that reason the bench waits for `done` and then compares the whole logged exchange sequence, pop count, receive stream, chip-select falls and `enq` count against values computed from the length and the modelled frame number. All outputs are sampled a fraction of a cycle after the falling edge, once the stall inputs for that cycle have been driven, so a logged `xfer_start` is always one the design takes at the next rising edge.

// File: rtl/fqs_pkg.sv
// Shared types of the frame queue burst sequencer.
package fqs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADMIT, ST_QON, ST_CSL, ST_ISSUE, ST_WAIT,
        ST_PRES, ST_CSH, ST_QOFF, ST_ENQ, ST_DONE
    } seq_state_t;

    typedef enum logic [1:0] {PH_CMD, PH_HDR, PH_PAY, PH_PAD} burst_phase_t;

    typedef enum logic [1:0] {
        FQ_OK        = 2'd0,
        FQ_ERR_LEN   = 2'd1,
        FQ_ERR_SPACE = 2'd2
    } fq_err_t;

    localparam logic DIR_TX = 1'b0;
    localparam logic DIR_RX = 1'b1;

endpackage

// File: rtl/fqs_admit.sv
// Request screening: rejects over-long frames and transmit frames that
// would not fit in the reported free queue space.
// Assumes: inputs are the latched request; the result is purely combinational.
module fqs_admit
    import fqs_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int MAX_FRAME   = 1518,
    parameter int TX_OVERHEAD = 8
) (
    input  logic             dir,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] free,
    output fq_err_t          verdict
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] need;
    logic             too_long;
    logic             no_room;

    // Length limit first, then space check for transmit only.
    always_comb begin
        need     = {1'b0, len} + SUM_W'(TX_OVERHEAD);
        too_long = ({1'b0, len} > SUM_W'(MAX_FRAME));
        no_room  = (dir == DIR_TX) && (need > {1'b0, free});
        if (too_long)     verdict = FQ_ERR_LEN;
        else if (no_room) verdict = FQ_ERR_SPACE;
        else              verdict = FQ_OK;
    end
endmodule

// File: rtl/fqs_tx_hdr.sv
// Transmit header source: keeps the rolling frame number and serves the
// four header bytes, least significant byte of each 16-bit field first.
// Assumes: adv pulses once per completed transmit burst.
module fqs_tx_hdr #(
    parameter int LEN_W   = 16,
    parameter int FID_W   = 6,
    parameter int IRQ_BIT = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [LEN_W-1:0] len,
    input  logic [1:0]       idx,
    output logic [7:0]       hdr_byte,
    output logic [FID_W-1:0] fid
);
    logic [15:0] ctrl;
    logic [15:0] cnt16;

    // Frame number counter, wraps naturally at its width.
    always_ff @(posedge clk) begin
        if (!rst_n)   fid <= '0;
        else if (adv) fid <= fid + 1'b1;
    end

    // Header byte selection by position inside the header.
    always_comb begin
        ctrl            = '0;
        ctrl[IRQ_BIT]   = 1'b1;
        ctrl[FID_W-1:0] = fid;
        cnt16           = 16'(len);
        unique case (idx)
            2'd0: hdr_byte = ctrl[7:0];
            2'd1: hdr_byte = ctrl[15:8];
            2'd2: hdr_byte = cnt16[7:0];
            default: hdr_byte = cnt16[15:8];
        endcase
    end

    a_r6_fid_advances: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> fid == $past(fid) + 1'b1);
endmodule

// File: rtl/fqs_burst_ctl.sv
// Burst controller: accepts a request, runs queue access and the chip-select
// window, walks command, header, payload and padding exchanges, and closes.
// Assumes: one byte exchange outstanding at a time; xfer_done is ignored
// outside the waiting state.
module fqs_burst_ctl
    import fqs_pkg::*;
#(
    parameter int         LEN_W     = 16,
    parameter logic [7:0] CMD_WR    = 8'hF0,
    parameter logic [7:0] CMD_RD    = 8'h80,
    parameter int         TX_HDR_N  = 4,
    parameter int         RX_SKIP_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_dir,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] req_free,
    output logic             busy,
    output logic             done,
    output fq_err_t          err_code,
    input  fq_err_t          adm_verdict,
    output logic             lat_dir,
    output logic [LEN_W-1:0] lat_len,
    output logic [LEN_W-1:0] lat_free,
    output logic [1:0]       hdr_idx,
    input  logic [7:0]       hdr_byte,
    output logic             fid_adv,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    input  logic             rx_ready,
    output logic             cs_n,
    output logic             qacc,
    output logic             enq,
    output logic             xfer_start,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx
);
    localparam logic [LEN_W-1:0] TX_HDR_LAST = LEN_W'(TX_HDR_N - 1);
    localparam logic [LEN_W-1:0] RX_HDR_LAST = LEN_W'(RX_SKIP_N - 1);

    seq_state_t       st_q;
    burst_phase_t     ph_q, nx_ph;
    logic [LEN_W-1:0] cnt_q, nx_cnt;
    logic             nx_end;
    logic             dir_q;
    logic [LEN_W-1:0] len_q, free_q;
    fq_err_t          err_q;
    logic [7:0]       rx_q;
    logic [1:0]       pad_n;
    logic [LEN_W-1:0] hdr_last;
    logic             can_issue;

    assign lat_dir  = dir_q;
    assign lat_len  = len_q;
    assign lat_free = free_q;
    assign hdr_idx  = cnt_q[1:0];
    assign pad_n    = 2'd0 - len_q[1:0];
    assign hdr_last = (dir_q == DIR_TX) ? TX_HDR_LAST : RX_HDR_LAST;

    // Step to the following exchange: phase, index and end-of-burst flag.
    always_comb begin
        nx_ph  = ph_q;
        nx_cnt = cnt_q + 1'b1;
        nx_end = 1'b0;
        unique case (ph_q)
            PH_CMD: begin
                nx_ph  = PH_HDR;
                nx_cnt = '0;
            end
            PH_HDR: if (cnt_q == hdr_last) begin
                nx_cnt = '0;
                if (len_q != '0) nx_ph  = PH_PAY;
                else             nx_end = 1'b1;
            end
            PH_PAY: if (cnt_q == len_q - 1'b1) begin
                nx_cnt = '0;
                if (pad_n != 2'd0) nx_ph  = PH_PAD;
                else               nx_end = 1'b1;
            end
            default: if (cnt_q[1:0] == pad_n - 2'd1) nx_end = 1'b1;
        endcase
    end

    // A transmit payload exchange waits for a source byte.
    assign can_issue = !((ph_q == PH_PAY) && (dir_q == DIR_TX) && !tx_valid);

    // Sequencer state, request latch and exchange bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ph_q   <= PH_CMD;
            cnt_q  <= '0;
            dir_q  <= DIR_TX;
            len_q  <= '0;
            free_q <= '0;
            err_q  <= FQ_OK;
            rx_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    st_q   <= ST_ADMIT;
                    dir_q  <= req_dir;
                    len_q  <= req_len;
                    free_q <= req_free;
                end
                ST_ADMIT: begin
                    err_q <= adm_verdict;
                    st_q  <= (adm_verdict != FQ_OK) ? ST_DONE : ST_QON;
                end
                ST_QON: st_q <= ST_CSL;
                ST_CSL: begin
                    st_q  <= ST_ISSUE;
                    ph_q  <= PH_CMD;
                    cnt_q <= '0;
                end
                ST_ISSUE: if (can_issue) st_q <= ST_WAIT;
                ST_WAIT: if (xfer_done) begin
                    if ((ph_q == PH_PAY) && (dir_q == DIR_RX)) begin
                        rx_q <= xfer_rx;
                        st_q <= ST_PRES;
                    end else begin
                        ph_q  <= nx_ph;
                        cnt_q <= nx_cnt;
                        st_q  <= nx_end ? ST_CSH : ST_ISSUE;
                    end
                end
                ST_PRES: if (rx_ready) begin
                    ph_q  <= nx_ph;
                    cnt_q <= nx_cnt;
                    st_q  <= nx_end ? ST_CSH : ST_ISSUE;
                end
                ST_CSH:  st_q <= ST_QOFF;
                ST_QOFF: st_q <= (dir_q == DIR_TX) ? ST_ENQ : ST_DONE;
                ST_ENQ:  st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the sequencer state.
    always_comb begin
        busy       = (st_q != ST_IDLE);
        done       = (st_q == ST_DONE);
        err_code   = err_q;
        qacc       = (st_q == ST_QON) || (st_q == ST_CSL) || (st_q == ST_ISSUE) ||
                     (st_q == ST_WAIT) || (st_q == ST_PRES) || (st_q == ST_CSH);
        cs_n       = !((st_q == ST_CSL) || (st_q == ST_ISSUE) ||
                       (st_q == ST_WAIT) || (st_q == ST_PRES));
        enq        = (st_q == ST_ENQ);
        fid_adv    = (st_q == ST_ENQ);
        xfer_start = (st_q == ST_ISSUE) && can_issue;
        tx_pop     = xfer_start && (ph_q == PH_PAY) && (dir_q == DIR_TX);
        rx_valid   = (st_q == ST_PRES);
        rx_data    = rx_q;
    end

    // Byte to send for the current exchange.
    always_comb begin
        unique case (ph_q)
            PH_CMD:  xfer_tx = (dir_q == DIR_TX) ? CMD_WR : CMD_RD;
            PH_HDR:  xfer_tx = (dir_q == DIR_TX) ? hdr_byte : 8'h00;
            PH_PAY:  xfer_tx = (dir_q == DIR_TX) ? tx_data : 8'h00;
            default: xfer_tx = 8'h00;
        endcase
    end

    a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    a_r4_cs_inside_qacc: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> qacc);
    a_r7_enq_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        enq |-> cs_n && !qacc);
    a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
    a_r9_no_start_pending: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !xfer_start);
    a_r10_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
endmodule

// File: rtl/fq_spi_burst_seq.sv
// Top of the frame queue burst sequencer: ties request screening, the
// header source and the burst controller together.
// Assumes: a byte exchange port that answers every start with one done.
module fq_spi_burst_seq
    import fqs_pkg::*;
#(
    parameter int         LEN_W     = 16,
    parameter int         MAX_FRAME = 1518,
    parameter int         FID_W     = 6,
    parameter logic [7:0] CMD_WR    = 8'hF0,
    parameter logic [7:0] CMD_RD    = 8'h80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_dir,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LEN_W-1:0] req_free,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err_code,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_pop,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    input  logic             rx_ready,
    output logic             cs_n,
    output logic             qacc,
    output logic             enq,
    output logic             xfer_start,
    output logic [7:0]       xfer_tx,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_rx
);
    localparam int TX_HDR_N    = 4;
    localparam int RX_SKIP_N   = 8;
    localparam int TX_OVERHEAD = 2 * TX_HDR_N;

    fq_err_t          verdict, err_e;
    logic             lat_dir;
    logic [LEN_W-1:0] lat_len, lat_free;
    logic [1:0]       hdr_idx;
    logic [7:0]       hdr_byte;
    logic             fid_adv;
    logic [FID_W-1:0] fid;

    assign err_code = err_e;

    fqs_admit #(.LEN_W(LEN_W), .MAX_FRAME(MAX_FRAME), .TX_OVERHEAD(TX_OVERHEAD)) u_admit (
        .dir(lat_dir), .len(lat_len), .free(lat_free), .verdict(verdict));

    fqs_tx_hdr #(.LEN_W(LEN_W), .FID_W(FID_W), .IRQ_BIT(15)) u_hdr (
        .clk(clk), .rst_n(rst_n), .adv(fid_adv), .len(lat_len), .idx(hdr_idx),
        .hdr_byte(hdr_byte), .fid(fid));

    fqs_burst_ctl #(.LEN_W(LEN_W), .CMD_WR(CMD_WR), .CMD_RD(CMD_RD),
                    .TX_HDR_N(TX_HDR_N), .RX_SKIP_N(RX_SKIP_N)) u_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
        .req_len(req_len), .req_free(req_free), .busy(busy), .done(done),
        .err_code(err_e), .adm_verdict(verdict), .lat_dir(lat_dir),
        .lat_len(lat_len), .lat_free(lat_free), .hdr_idx(hdr_idx),
        .hdr_byte(hdr_byte), .fid_adv(fid_adv), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .cs_n(cs_n), .qacc(qacc),
        .enq(enq), .xfer_start(xfer_start), .xfer_tx(xfer_tx),
        .xfer_done(xfer_done), .xfer_rx(xfer_rx));

    // Exchanges started since the last accepted request, for the R2/R3 check.
    logic [LEN_W:0] starts_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 starts_q <= '0;
        else if (req_valid && !busy) starts_q <= '0;
        else if (xfer_start)         starts_q <= starts_q + 1'b1;
    end

    a_r2_no_bus_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
        done && (err_code != 2'd0) |-> starts_q == '0);
endmodule

// File: tb/fq_spi_burst_seq_tb.sv
module fq_spi_burst_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LOG_N      = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_dir = 1'b0;
    logic [15:0] req_len = '0, req_free = '0;
    logic        busy, done;
    logic [1:0]  err_code;
    logic        tx_valid = 1'b0;
    logic [7:0]  tx_data;
    logic        tx_pop, rx_valid, rx_ready = 1'b0;
    logic [7:0]  rx_data;
    logic        cs_n, qacc, enq, xfer_start;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = '0;

    int tests = 0, fails = 0;
    int cyc = 0, pidx = 0, cur_len = 0;
    int lg_n = 0, rxc_n = 0, cs_falls = 0, qa_rises = 0, enq_cnt = 0, ord_viol = 0;
    int wait_c = 0, resp_k = 0, n_tx_ok = 0;
    logic [7:0] lg  [LOG_N];
    logic [7:0] rxc [LOG_N];
    bit cs_prev = 1'b1, qa_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign tx_data = 8'((pidx * 13 + cur_len) % 256);

    fq_spi_burst_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dir(req_dir),
        .req_len(req_len), .req_free(req_free), .busy(busy), .done(done),
        .err_code(err_code), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .cs_n(cs_n), .qacc(qacc), .enq(enq),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] resp(input int k);
        if (k == 0) return 8'hEE;
        if (k < 9)  return 8'(8'hA0 + k);
        return 8'((k * 7 + 3 + cur_len) % 256);
    endfunction

    function automatic logic [7:0] exp_tx(input bit dir, input int len, input int fid, input int k);
        if (k == 0) return dir ? 8'h80 : 8'hF0;
        if (dir)    return 8'h00;
        if (k == 1) return 8'(fid % 64);
        if (k == 2) return 8'h80;
        if (k == 3) return 8'(len % 256);
        if (k == 4) return 8'(len / 256);
        if (k < 5 + len) return 8'(((k - 5) * 13 + len) % 256);
        return 8'h00;
    endfunction

    // Environment: drives stall inputs and the exchange responder, then samples.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tx_valid  = (cyc % 5) != 2;
            rx_ready  = (cyc % 4) != 1;
            xfer_done = 1'b0;
            if (wait_c > 0) begin
                wait_c--;
                if (wait_c == 0) begin
                    xfer_done = 1'b1;
                    xfer_rx   = resp(resp_k);
                end
            end
            #1;
            if (!cs_n && !qacc) ord_viol++;
            if (xfer_start && cs_n) ord_viol++;
            if (enq && (qacc || !cs_n)) ord_viol++;
            if (cs_prev && !cs_n) cs_falls++;
            if (!qa_prev && qacc) qa_rises++;
            if (enq) enq_cnt++;
            cs_prev = cs_n;
            qa_prev = qacc;
            if (xfer_start) begin
                if (wait_c != 0) ord_viol++;
                if (lg_n < LOG_N) lg[lg_n] = xfer_tx;
                resp_k = lg_n;
                lg_n++;
                if (tx_pop) pidx++;
                wait_c = 1 + (cyc % 3);
            end
            if (rx_valid && rx_ready) begin
                if (rxc_n < LOG_N) rxc[rxc_n] = rx_data;
                rxc_n++;
            end
        end
    end

    task automatic run_req(input bit dir, input int len, input int free,
                           input int exp_err, input bit inject);
        int t;
        int exp_n;
        int mism;
        int first_bad;
        lg_n = 0; rxc_n = 0; pidx = 0; cs_falls = 0; qa_rises = 0; enq_cnt = 0;
        cur_len = len;
        @(negedge clk);
        req_valid = 1'b1; req_dir = dir; req_len = 16'(len); req_free = 16'(free);
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        t = 1;
        while (!done && t < 50000) begin
            @(negedge clk);
            req_valid = inject && (t == 5);
            req_dir   = ~dir;
            #2;
            t++;
        end
        req_valid = 1'b0;
        chk(done == 1'b1, "R1 done reached", int'(done), 1);
        chk(int'(err_code) == exp_err, exp_err == 1 ? "R2 err_code" : "R3 err_code",
            int'(err_code), exp_err);
        if (exp_err != 0) begin
            chk(t == 2, "R2 reject timing", t, 2);
            chk(lg_n == 0 && cs_falls == 0 && qa_rises == 0,
                exp_err == 1 ? "R2 no bus activity" : "R3 no bus activity",
                lg_n + cs_falls + qa_rises, 0);
        end else begin
            exp_n = (dir ? 9 : 5) + len + ((4 - len % 4) % 4);
            mism = 0; first_bad = -1;
            for (int k = 0; k < exp_n && k < LOG_N; k++)
                if (lg[k] !== exp_tx(dir, len, n_tx_ok, k)) begin
                    mism++;
                    if (first_bad < 0) first_bad = k;
                end
            chk(lg_n == exp_n, dir ? "R8 exchange count" : "R5 exchange count", lg_n, exp_n);
            chk(mism == 0, dir ? "R8 sent bytes" : "R5 R6 sent bytes", first_bad, -1);
            chk(cs_falls == 1 && qa_rises == 1, "R4 single window", cs_falls, 1);
            chk(enq_cnt == (dir ? 0 : 1), "R7 enq count", enq_cnt, dir ? 0 : 1);
            if (!dir) begin
                chk(pidx == len, "R5 pop count", pidx, len);
                n_tx_ok++;
            end else begin
                mism = 0;
                for (int j = 0; j < len && j < LOG_N; j++)
                    if (rxc[j] !== 8'(((9 + j) * 7 + 3 + len) % 256)) mism++;
                chk(rxc_n == len, "R8 rx stream count", rxc_n, len);
                chk(mism == 0, "R9 rx stream data", mism, 0);
            end
        end
        chk(ord_viol == 0, "R10 R4 ordering", ord_viol, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(cs_n && !qacc && !busy && !done && !enq && !xfer_start, "R11 reset state",
            int'({cs_n, qacc, busy, done, enq, xfer_start}), 32);
        for (int len = 0; len < 70; len++) run_req(1'b0, len, len + 8, 0, 1'b0); // R6 wrap
        run_req(1'b0, 10, 17, 2, 1'b0);          // R3 one short of room
        run_req(1'b0, 1519, 4000, 1, 1'b0);      // R2 over limit
        run_req(1'b1, 1519, 0, 1, 1'b0);         // R2 receive over limit
        run_req(1'b0, 3, 11, 0, 1'b0);           // R6 number unchanged by rejects
        run_req(1'b0, 1518, 1526, 0, 1'b0);      // R2 limit accepted
        for (int len = 0; len < 41; len++) run_req(1'b1, len, 0, 0, 1'b0);
        run_req(1'b0, 10, 40, 0, 1'b1);          // R1 request while busy ignored
        cs_falls = 0; lg_n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); #2;
            if (done || busy) lg_n++;
        end
        chk(lg_n == 0 && cs_falls == 0, "R1 ignored request", lg_n + cs_falls, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule